// File: doc/BRIEF.md
# Two-Level Page Table Walker

This block turns a 32-bit virtual address into a 40-bit physical address by reading two entries of a page table that lives in memory. The virtual address is cut into a 10-bit first index (bits 31..22), a 10-bit second index (bits 21..12) and a 12-bit offset inside a 4 KB page. The walker reads the first-level entry relative to a table-root address supplied on an input. That entry gives the base of a second-level table. It then reads the second-level entry, and that entry gives the physical page number of the target page.

Every entry is 32 bits wide. Bit 0 is the valid flag, bit 1 allows loads, bit 2 allows stores and bit 3 allows user-mode access. Bits 31..4 hold a 28-bit physical page number. An entry with a clear valid flag ends the walk with a page fault. An entry that forbids the requested access ends it with an access fault. Both rules are applied at each of the two levels.

A requester hands in one translation at a time over a valid/ready handshake. The walker issues at most one memory read at a time and answers with a single-cycle response that carries the physical address or the fault.

Top module: `ptw_top`

## Requirements
- R1: The first memory read of a walk targets `ptbr + vaddr[31:22]*4`.
- R2: After a first-level entry that passes its checks, the second read targets `{entry[31:4], 12'h000} + vaddr[21:12]*4`.
- R3: A walk with no fault answers with `rsp_paddr = {second_entry[31:4], vaddr[11:0]}`, so the offset passes through unchanged.
- R4: An entry with bit 0 clear ends the walk at once with `rsp_page_fault=1` and `rsp_access_fault=0`. No further memory read is issued for that walk.
- R5: A valid entry ends the walk with `rsp_access_fault=1` in any of these cases: a store reaches an entry with bit 2 clear, a load reaches an entry with bit 1 clear, or a user access reaches an entry with bit 3 clear. The two fault flags are never set together.
- R6: `mem_req_valid` stays high with a stable `mem_req_addr` until `mem_req_ready` is seen. After acceptance, no new read is issued before `mem_rsp_valid` arrives.
- R7: `req_ready` is high only while the walker is idle, and a request is taken only when `req_valid` and `req_ready` are both high.
- R8: Each accepted request produces exactly one `rsp_valid` pulse, and that pulse is one cycle long.
- R9: After reset, `req_ready=1`, `mem_req_valid=0` and `rsp_valid=0`.
- R10: On a fault, `rsp_fault_level` is 0 when the first-level entry faulted and 1 when the second-level entry faulted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Translation request present |
| req_ready | output | 1 | Walker idle and able to take a request |
| req_vaddr | input | 32 | Virtual address to translate |
| req_store | input | 1 | 1 = store access, 0 = load access |
| req_user | input | 1 | 1 = user-mode access |
| ptbr | input | 40 | Physical address of the first-level table |
| mem_req_valid | output | 1 | Memory read request |
| mem_req_ready | input | 1 | Memory accepts the read request |
| mem_req_addr | output | 40 | Physical address of the entry to read |
| mem_rsp_valid | input | 1 | Read data returned |
| mem_rsp_data | input | 32 | Page table entry read from memory |
| rsp_valid | output | 1 | One-cycle response pulse |
| rsp_paddr | output | 40 | Translated physical address (zero on a fault) |
| rsp_page_fault | output | 1 | Walk ended on an entry with a clear valid flag |
| rsp_access_fault | output | 1 | Walk ended on an entry that forbids the access |
| rsp_fault_level | output | 1 | Level of the faulting entry |

## Verification
The word-alignment property on `mem_req_addr` holds only if `ptbr` has its two low bits clear. It also depends on the memory never returning data before its read has been accepted. The stimulus always supplies a root address aligned to 4 KB. The bench's memory model raises `mem_rsp_valid` only after it has granted `mem_req_ready`, and only for the read it granted. The sweep covers every combination of the low four flag bits at both levels, for loads and stores, in user and supervisor mode. It varies the acceptance and return delays between walks, so that each ordering of the handshake is exercised.

// File: rtl/ptw_pkg.sv
package ptw_pkg;

    localparam int VA_W   = 32;
    localparam int IDX_W  = 10;
    localparam int OFF_W  = 12;
    localparam int PA_W   = 40;
    localparam int PPN_W  = PA_W - OFF_W;
    localparam int FLAG_W = 4;
    localparam int PTE_W  = PPN_W + FLAG_W;
    localparam int ENT_SH = 2;  // log2 of entry size in bytes

    typedef struct packed {
        logic [PPN_W-1:0] ppn;
        logic             user_ok;
        logic             wr_ok;
        logic             rd_ok;
        logic             valid;
    } pte_t;

    typedef struct packed {
        logic [IDX_W-1:0] idx_hi;
        logic [IDX_W-1:0] idx_lo;
        logic [OFF_W-1:0] offset;
        logic             store;
        logic             user;
    } walk_req_t;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_RD_L1 = 2'd1,
        ST_RD_L2 = 2'd2,
        ST_RESP  = 2'd3
    } walk_state_e;

    function automatic walk_req_t split_vaddr(input logic [VA_W-1:0] va,
                                              input logic st,
                                              input logic us);
        walk_req_t r;
        r.idx_hi = va[VA_W-1 -: IDX_W];
        r.idx_lo = va[OFF_W +: IDX_W];
        r.offset = va[OFF_W-1:0];
        r.store  = st;
        r.user   = us;
        return r;
    endfunction

endpackage

// File: rtl/ptw_addr_gen.sv
module ptw_addr_gen
    import ptw_pkg::*;
(
    input  logic [PA_W-1:0]  table_base,
    input  logic [IDX_W-1:0] index,
    output logic [PA_W-1:0]  entry_addr
);
    localparam int PAD_W = PA_W - IDX_W - ENT_SH;

    logic [PA_W-1:0] scaled;

    always_comb begin
        scaled     = {{PAD_W{1'b0}}, index, {ENT_SH{1'b0}}};
        entry_addr = table_base + scaled;
    end
endmodule

// File: rtl/ptw_entry_check.sv
module ptw_entry_check
    import ptw_pkg::*;
(
    input  logic [PTE_W-1:0] raw_entry,
    input  logic             is_store,
    input  logic             is_user,
    output logic             page_fault,
    output logic             access_fault,
    output logic [PPN_W-1:0] ppn
);
    pte_t ent;
    logic denied;

    always_comb begin
        ent          = pte_t'(raw_entry);
        denied       = (is_store && !ent.wr_ok)
                     || (!is_store && !ent.rd_ok)
                     || (is_user && !ent.user_ok);
        page_fault   = !ent.valid;
        access_fault = ent.valid && denied;
        ppn          = ent.ppn;
    end
endmodule

// File: rtl/ptw_top.sv
module ptw_top
    import ptw_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             req_valid,
    output logic             req_ready,
    input  logic [VA_W-1:0]  req_vaddr,
    input  logic             req_store,
    input  logic             req_user,
    input  logic [PA_W-1:0]  ptbr,
    output logic             mem_req_valid,
    input  logic             mem_req_ready,
    output logic [PA_W-1:0]  mem_req_addr,
    input  logic             mem_rsp_valid,
    input  logic [PTE_W-1:0] mem_rsp_data,
    output logic             rsp_valid,
    output logic [PA_W-1:0]  rsp_paddr,
    output logic             rsp_page_fault,
    output logic             rsp_access_fault,
    output logic             rsp_fault_level
);
    walk_state_e      state_q;
    walk_req_t        req_q;
    logic             issued_q;
    logic [PA_W-1:0]  base_q;
    logic [PA_W-1:0]  paddr_q;
    logic             pf_q, af_q, lvl_q;

    logic [IDX_W-1:0] cur_idx;
    logic             ent_pf, ent_af;
    logic [PPN_W-1:0] ent_ppn;
    logic             walking, entry_arrived;

    always_comb begin
        walking       = (state_q == ST_RD_L1) || (state_q == ST_RD_L2);
        cur_idx       = (state_q == ST_RD_L2) ? req_q.idx_lo : req_q.idx_hi;
        entry_arrived = walking && issued_q && mem_rsp_valid;
    end

    ptw_addr_gen u_addr (
        .table_base (base_q),
        .index      (cur_idx),
        .entry_addr (mem_req_addr)
    );

    ptw_entry_check u_check (
        .raw_entry    (mem_rsp_data),
        .is_store     (req_q.store),
        .is_user      (req_q.user),
        .page_fault   (ent_pf),
        .access_fault (ent_af),
        .ppn          (ent_ppn)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q  <= ST_IDLE;
            req_q    <= '0;
            issued_q <= 1'b0;
            base_q   <= '0;
            paddr_q  <= '0;
            pf_q     <= 1'b0;
            af_q     <= 1'b0;
            lvl_q    <= 1'b0;
        end else begin
            case (state_q)
                ST_IDLE: begin
                    if (req_valid) begin
                        req_q    <= split_vaddr(req_vaddr, req_store, req_user);
                        base_q   <= ptbr;
                        issued_q <= 1'b0;
                        paddr_q  <= '0;
                        pf_q     <= 1'b0;
                        af_q     <= 1'b0;
                        lvl_q    <= 1'b0;
                        state_q  <= ST_RD_L1;
                    end
                end
                ST_RD_L1, ST_RD_L2: begin
                    if (mem_req_valid && mem_req_ready) begin
                        issued_q <= 1'b1;
                    end
                    if (entry_arrived) begin
                        if (ent_pf || ent_af) begin
                            pf_q    <= ent_pf;
                            af_q    <= ent_af;
                            lvl_q   <= (state_q == ST_RD_L2);
                            state_q <= ST_RESP;
                        end else if (state_q == ST_RD_L1) begin
                            base_q   <= {ent_ppn, {OFF_W{1'b0}}};
                            issued_q <= 1'b0;
                            state_q  <= ST_RD_L2;
                        end else begin
                            paddr_q <= {ent_ppn, req_q.offset};
                            state_q <= ST_RESP;
                        end
                    end
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    always_comb begin
        req_ready        = (state_q == ST_IDLE);
        mem_req_valid    = walking && !issued_q;
        rsp_valid        = (state_q == ST_RESP);
        rsp_paddr        = paddr_q;
        rsp_page_fault   = pf_q;
        rsp_access_fault = af_q;
        rsp_fault_level  = lvl_q;
    end
endmodule

// File: rtl/ptw_checker.sv
module ptw_checker
    import ptw_pkg::*;
(
    input logic            clk,
    input logic            rst,
    input logic            req_valid,
    input logic            req_ready,
    input logic [VA_W-1:0] req_vaddr,
    input logic            mem_req_valid,
    input logic            mem_req_ready,
    input logic [PA_W-1:0] mem_req_addr,
    input logic            rsp_valid,
    input logic [PA_W-1:0] rsp_paddr,
    input logic            rsp_page_fault,
    input logic            rsp_access_fault
);
    logic [OFF_W-1:0] off_seen;

    always_ff @(posedge clk) begin
        if (rst) off_seen <= '0;
        else if (req_valid && req_ready) off_seen <= req_vaddr[OFF_W-1:0];
    end

    assert_word_aligned_R1: assert property (@(posedge clk) disable iff (rst)
        mem_req_valid |-> (mem_req_addr[ENT_SH-1:0] == '0));

    assert_offset_kept_R3: assert property (@(posedge clk) disable iff (rst)
        (rsp_valid && !rsp_page_fault && !rsp_access_fault)
            |-> (rsp_paddr[OFF_W-1:0] == off_seen));

    assert_fault_exclusive_R5: assert property (@(posedge clk) disable iff (rst)
        rsp_valid |-> !(rsp_page_fault && rsp_access_fault));

    assert_req_held_R6: assert property (@(posedge clk) disable iff (rst)
        (mem_req_valid && !mem_req_ready) |=> (mem_req_valid && $stable(mem_req_addr)));

    assert_one_outstanding_R6: assert property (@(posedge clk) disable iff (rst)
        (mem_req_valid && mem_req_ready) |=> !mem_req_valid);

    assert_idle_quiet_R7: assert property (@(posedge clk) disable iff (rst)
        req_ready |-> (!mem_req_valid && !rsp_valid));

    assert_pulse_single_R8: assert property (@(posedge clk) disable iff (rst)
        rsp_valid |=> !rsp_valid);
endmodule

bind ptw_top ptw_checker u_chk (
    .clk              (clk),
    .rst              (rst),
    .req_valid        (req_valid),
    .req_ready        (req_ready),
    .req_vaddr        (req_vaddr),
    .mem_req_valid    (mem_req_valid),
    .mem_req_ready    (mem_req_ready),
    .mem_req_addr     (mem_req_addr),
    .rsp_valid        (rsp_valid),
    .rsp_paddr        (rsp_paddr),
    .rsp_page_fault   (rsp_page_fault),
    .rsp_access_fault (rsp_access_fault)
);

// File: tb/ptw_top_tb.sv
`timescale 1ns/1ps
module ptw_top_tb;
    logic        clk = 1'b0;
    logic        rst;
    logic        req_valid, req_ready, req_store, req_user;
    logic [31:0] req_vaddr;
    logic [39:0] ptbr;
    logic        mem_req_valid, mem_req_ready;
    logic [39:0] mem_req_addr;
    logic        mem_rsp_valid;
    logic [31:0] mem_rsp_data;
    logic        rsp_valid, rsp_page_fault, rsp_access_fault, rsp_fault_level;
    logic [39:0] rsp_paddr;

    int total = 0;
    int bad   = 0;
    bit finished = 1'b0;

    always #2 clk = ~clk;

    ptw_top u_dut (
        .clk(clk), .rst(rst),
        .req_valid(req_valid), .req_ready(req_ready), .req_vaddr(req_vaddr),
        .req_store(req_store), .req_user(req_user), .ptbr(ptbr),
        .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
        .mem_req_addr(mem_req_addr), .mem_rsp_valid(mem_rsp_valid),
        .mem_rsp_data(mem_rsp_data), .rsp_valid(rsp_valid), .rsp_paddr(rsp_paddr),
        .rsp_page_fault(rsp_page_fault), .rsp_access_fault(rsp_access_fault),
        .rsp_fault_level(rsp_fault_level)
    );

    task automatic chk(input bit ok, input string tag,
                       input logic [63:0] act, input logic [63:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // R4 / R5 expected fault of one entry
    function automatic logic [1:0] exp_fault(input logic [31:0] e, input logic st, input logic us);
        logic pf, af;
        pf = !e[0];
        af = e[0] && ((st && !e[2]) || (!st && !e[1]) || (us && !e[3]));
        return {pf, af};
    endfunction

    // Serve one memory read: check address and hold, grant, return data.
    task automatic serve(input logic [39:0] exp_addr, input logic [31:0] data,
                         input int rdly, input int sdly, input string tag);
        chk(mem_req_valid === 1'b1, {tag, " read issued"}, 64'(mem_req_valid), 1);
        chk(mem_req_addr === exp_addr, {tag, " read address"}, 64'(mem_req_addr), 64'(exp_addr));
        chk(req_ready === 1'b0, "R7 busy while walking", 64'(req_ready), 0);
        for (int k = 0; k < rdly; k++) begin
            @(negedge clk);
            chk(mem_req_valid === 1'b1 && mem_req_addr === exp_addr, "R6 request held",
                64'(mem_req_addr), 64'(exp_addr));
        end
        mem_req_ready = 1'b1;
        @(negedge clk);
        mem_req_ready = 1'b0;
        chk(mem_req_valid === 1'b0, "R6 single outstanding", 64'(mem_req_valid), 0);
        for (int k = 0; k < sdly; k++) begin
            @(negedge clk);
            chk(mem_req_valid === 1'b0, "R6 no read before data", 64'(mem_req_valid), 0);
        end
        mem_rsp_valid = 1'b1;
        mem_rsp_data  = data;
        @(negedge clk);
        mem_rsp_valid = 1'b0;
        mem_rsp_data  = '0;
    endtask

    task automatic walk(input logic [31:0] va, input logic st, input logic us,
                        input logic [39:0] pt, input logic [31:0] e1, input logic [31:0] e2,
                        input int rdly, input int sdly);
        logic [1:0]  f1, f2;
        logic [39:0] a1, a2, pa;
        logic        exp_pf, exp_af, exp_lvl;
        f1 = exp_fault(e1, st, us);
        f2 = exp_fault(e2, st, us);
        a1 = pt + {28'd0, va[31:22], 2'b00};
        a2 = {e1[31:4], 12'h000} + {28'd0, va[21:12], 2'b00};
        @(negedge clk);
        chk(req_ready === 1'b1, "R7 ready when idle", 64'(req_ready), 1);
        req_valid = 1'b1; req_vaddr = va; req_store = st; req_user = us; ptbr = pt;
        @(negedge clk);
        req_valid = 1'b0; req_vaddr = ~va; ptbr = '0;
        serve(a1, e1, rdly, sdly, "R1");
        if (f1 != 2'b00) begin
            exp_pf = f1[1]; exp_af = f1[0]; exp_lvl = 1'b0; pa = '0;
            chk(mem_req_valid === 1'b0, "R4 no second read after first-level fault",
                64'(mem_req_valid), 0);
        end else begin
            serve(a2, e2, sdly, rdly, "R2");
            exp_pf = f2[1]; exp_af = f2[0]; exp_lvl = 1'b1;
            pa = (f2 != 2'b00) ? 40'd0 : {e2[31:4], va[11:0]};
        end
        chk(rsp_valid === 1'b1, "R8 response pulse", 64'(rsp_valid), 1);
        chk(rsp_page_fault === exp_pf, "R4 page fault flag", 64'(rsp_page_fault), 64'(exp_pf));
        chk(rsp_access_fault === exp_af, "R5 access fault flag", 64'(rsp_access_fault), 64'(exp_af));
        if (exp_pf || exp_af)
            chk(rsp_fault_level === exp_lvl, "R10 fault level", 64'(rsp_fault_level), 64'(exp_lvl));
        else
            chk(rsp_paddr === pa, "R3 physical address", 64'(rsp_paddr), 64'(pa));
        @(negedge clk);
        chk(rsp_valid === 1'b0, "R8 pulse one cycle", 64'(rsp_valid), 0);
        chk(req_ready === 1'b1 && mem_req_valid === 1'b0, "R7 back to idle",
            64'(req_ready), 1);
    endtask

    initial begin
        rst = 1'b1; req_valid = 0; req_vaddr = 0; req_store = 0; req_user = 0; ptbr = 0;
        mem_req_ready = 0; mem_rsp_valid = 0; mem_rsp_data = 0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk(req_ready === 1'b1, "R9 reset ready", 64'(req_ready), 1);
        chk(mem_req_valid === 1'b0, "R9 reset no read", 64'(mem_req_valid), 0);
        chk(rsp_valid === 1'b0, "R9 reset no response", 64'(rsp_valid), 0);

        // corner addresses, all rights granted
        walk(32'hFFFF_FFFF, 1'b1, 1'b1, 40'hFF_FFFF_F000, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 0, 0);
        walk(32'h0000_0000, 1'b0, 1'b0, 40'h00_0000_0000, 32'h0000_100F, 32'h0ABC_D00F, 2, 1);

        // sweep of both entries' flag nibbles, access kind and privilege
        for (int n = 0; n < 1024; n++) begin
            logic [3:0]  fl1, fl2;
            logic [31:0] va;
            fl1 = 4'(n >> 6);
            fl2 = 4'(n >> 2);
            va  = 32'(n) * 32'h9E37_79B1;
            walk(va, n[0], n[1], {28'(n * 3 + 1), 12'h000},
                 {28'(n * 13 + 5), fl1}, {28'(n * 7919 + 1), fl2}, n % 3, (n / 3) % 3);
        end

        finished = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            total++;
            bad++;
            $display("FAIL R8 watchdog actual=hung expected=done");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule